// File: doc/BRIEF.md
# Synthesizer Divider Programming Port

This block holds the settings that a clock synthesizer's divider chain runs from: a 9-bit feedback divide value, a 2-bit output divide select and a 2-bit test-select field. Two load paths write these settings.

The parallel path uses an active-low strobe. While the strobe is low, the parallel M and N pins flow straight into the active registers. When the strobe rises, the values freeze. The serial path has its own clock, data line and load strobe, and feeds a 14-slot shift register. A rising load strobe copies the frame into the active registers. Holding the load strobe high makes every serial clock edge update them directly.

The test-select field chooses what a single observation pin shows. A lock-range flag and a one-cycle update pulse tell downstream divider logic when to reload.

Every strobe, the serial clock and the serial data line are brought into the system clock domain through two flip-flops. Edges are found by comparing the synchronised level with its value one cycle earlier. As a result, each external event acts on the system clock edge that follows its second synchronizer stage.

Top module: `synth_prog_port`

## Requirements
- R1: After asynchronous reset the port shows the defaults M=25, N=0 and test field 0, with update_o low.
- R2: While par_load_ni is low, m_o and n_o follow par_m_i and par_n_i on every system clock.
- R3: Once par_load_ni has risen, later changes on par_m_i and par_n_i have no effect on m_o and n_o.
- R4: With par_load_ni high and ser_load_i low, each rising ser_clk_i shifts ser_data_i into the shift register, and the active m_o, n_o and t_o values do not change.
- R5: A frame is 14 bits sent first to last as T1, T0, a spare slot, N1, N0, M8 down to M0. The spare slot's value never reaches any output.
- R6: A rising ser_load_i copies the shift register's test, N and M fields to t_o, n_o and m_o. Those values stay after ser_load_i falls, including over a value latched earlier from the parallel path.
- R7: While ser_load_i is held high, each rising ser_clk_i updates t_o, n_o and m_o from the newly shifted register contents.
- R8: With parallel loading idle, test_o shows a value chosen by t_o: 0 gives constant low, 1 gives the synchronised serial data, 2 gives fb_div_i, and 3 gives out_clk_i.
- R9: While par_load_ni is low, test_o is low whatever the test field holds.
- R10: lock_ok_o is high exactly when m_o lies between 25 and 31 inclusive.
- R11: update_o is high for exactly one system clock each time m_o or n_o takes a new value, and stays low when a load writes the value already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| par_load_ni | input | 1 | Parallel load strobe, transparent while low |
| par_m_i | input | 9 | Parallel feedback divide value |
| par_n_i | input | 2 | Parallel output divide select |
| ser_clk_i | input | 1 | Serial shift clock, sampled on rising edges |
| ser_data_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Serial load strobe |
| fb_div_i | input | 1 | Feedback divider output, for observation |
| out_clk_i | input | 1 | Output clock, for observation |
| m_o | output | 9 | Active feedback divide value |
| n_o | output | 2 | Active output divide select |
| t_o | output | 2 | Active test-select field |
| test_o | output | 1 | Observation pin |
| lock_ok_o | output | 1 | M lies within the lock-valid range |
| update_o | output | 1 | One-cycle pulse when M or N changes |

## Verification
A shift register holding a wrong bit stays hidden until the next serial transfer. At that point it shows as a misplaced field value on m_o, n_o or t_o, so each frame is read back through the active outputs. It is also read back slot by slot while the load strobe is held high, where a misordered slot shows within one serial clock. A mode decode error shows on test_o or on m_o about three system clocks after the strobe moves. A missed or repeated update pulse is found by counting pulses per load, because update_o lasts only one cycle.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int FRAME_W = T_W + 1 + N_W + M_W;
  localparam int SYNC_N  = 2;
  localparam logic [M_W-1:0] M_RESET  = 9'd25;
  localparam logic [M_W-1:0] LOCK_MIN = 9'd25;
  localparam logic [M_W-1:0] LOCK_MAX = 9'd31;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW  = 2'd0,
    TSEL_SDAT = 2'd1,
    TSEL_FB   = 2'd2,
    TSEL_OUT  = 2'd3
  } tsel_e;

  // first bit sent ends at the MSB
  typedef struct packed {
    logic [T_W-1:0] t;
    logic           spare;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } frame_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
  import synth_cfg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   shift_i,
  input  logic   din_i,
  output frame_t frame_o,
  output frame_t frame_nx_o
);
  frame_t sr_q;

  assign frame_nx_o = frame_t'({sr_q[FRAME_W-2:0], din_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= frame_nx_o;
  end

  assign frame_o = sr_q;
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
  import synth_cfg_pkg::*;
(
  input  logic [T_W-1:0] sel_i,
  input  logic           force_low_i,
  input  logic           sdat_i,
  input  logic           fb_i,
  input  logic           out_i,
  output logic           test_o
);
  always_comb begin
    unique case (tsel_e'(sel_i))
      TSEL_LOW:  test_o = 1'b0;
      TSEL_SDAT: test_o = sdat_i;
      TSEL_FB:   test_o = fb_i;
      TSEL_OUT:  test_o = out_i;
      default:   test_o = 1'b0;
    endcase
    if (force_low_i) test_o = 1'b0;
  end
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
  import synth_cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           par_load_ni,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_load_i,
  input  logic           fb_div_i,
  input  logic           out_clk_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           test_o,
  output logic           lock_ok_o,
  output logic           update_o
);
  localparam int SW = 4;

  logic [SW-1:0] raw, syn;
  logic par_n_s, sld_s, sclk_s, sdat_s;
  logic sld_p, sclk_p;
  logic par_act, sld_rise, sclk_rise;

  assign raw = {par_load_ni, ser_load_i, ser_clk_i, ser_data_i};

  cfg_sync #(.W(SW), .STAGES(SYNC_N), .RST_VAL(4'b1000)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (syn)
  );

  assign {par_n_s, sld_s, sclk_s, sdat_s} = syn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sld_p  <= 1'b0;
      sclk_p <= 1'b0;
    end else begin
      sld_p  <= sld_s;
      sclk_p <= sclk_s;
    end
  end

  assign par_act   = !par_n_s;
  assign sld_rise  = sld_s && !sld_p;
  assign sclk_rise = sclk_s && !sclk_p;

  frame_t sr, sr_nx;

  cfg_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (sclk_rise && !par_act),
    .din_i      (sdat_s),
    .frame_o    (sr),
    .frame_nx_o (sr_nx)
  );

  logic [M_W-1:0] m_q, m_d;
  logic [N_W-1:0] n_q, n_d;
  logic [T_W-1:0] t_q, t_d;
  logic           upd_q;

  // parallel transparency wins; serial transfer overrides a parallel latch
  always_comb begin
    m_d = m_q;
    n_d = n_q;
    t_d = t_q;
    if (par_act) begin
      m_d = par_m_i;
      n_d = par_n_i;
    end else if (sld_rise) begin
      m_d = sr.m;
      n_d = sr.n;
      t_d = sr.t;
    end else if (sld_s && sclk_rise) begin
      m_d = sr_nx.m;
      n_d = sr_nx.n;
      t_d = sr_nx.t;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q   <= M_RESET;
      n_q   <= '0;
      t_q   <= '0;
      upd_q <= 1'b0;
    end else begin
      m_q   <= m_d;
      n_q   <= n_d;
      t_q   <= t_d;
      upd_q <= (m_d != m_q) || (n_d != n_q);
    end
  end

  cfg_test_mux u_tmux (
    .sel_i       (t_q),
    .force_low_i (par_act),
    .sdat_i      (sdat_s),
    .fb_i        (fb_div_i),
    .out_i       (out_clk_i),
    .test_o      (test_o)
  );

  assign m_o       = m_q;
  assign n_o       = n_q;
  assign t_o       = t_q;
  assign update_o  = upd_q;
  assign lock_ok_o = (m_q >= LOCK_MIN) && (m_q <= LOCK_MAX);
endmodule

// File: rtl/synth_prog_port_chk.sv
module synth_prog_port_chk
  import synth_cfg_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           par_act,
  input logic           sld_s,
  input logic [M_W-1:0] m_o,
  input logic [N_W-1:0] n_o,
  input logic [T_W-1:0] t_o,
  input logic           test_o,
  input logic           update_o
);
  assert_upd_means_change_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (m_o != $past(m_o)) || (n_o != $past(n_o)));

  assert_change_means_upd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((m_o != $past(m_o)) || (n_o != $past(n_o))) |-> update_o);

  assert_par_test_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_act |-> !test_o);

  assert_par_keeps_test_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_act |=> $stable(t_o));

  assert_shift_only_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_act && !sld_s) |=> ($stable(m_o) && $stable(n_o) && $stable(t_o)));
endmodule

bind synth_prog_port synth_prog_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .par_act  (par_act),
  .sld_s    (sld_s),
  .m_o      (m_o),
  .n_o      (n_o),
  .t_o      (t_o),
  .test_o   (test_o),
  .update_o (update_o)
);

// File: tb/synth_prog_port_tb.sv
module synth_prog_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_load_n = 1'b1;
  logic [8:0] par_m = 9'd0;
  logic [1:0] par_n = 2'd0;
  logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic       fb_div = 1'b0, out_clk = 1'b0;
  logic [8:0] m_o;
  logic [1:0] n_o, t_o;
  logic       test_o, lock_ok, update;

  int n_chk = 0, n_bad = 0, upd_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  synth_prog_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .par_load_ni(par_load_n), .par_m_i(par_m),
    .par_n_i(par_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .ser_load_i(ser_load), .fb_div_i(fb_div), .out_clk_i(out_clk),
    .m_o(m_o), .n_o(n_o), .t_o(t_o), .test_o(test_o),
    .lock_ok_o(lock_ok), .update_o(update)
  );

  always @(negedge clk) if (rst_n && update) upd_cnt++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req, input int m, input int n, input int t);
    chk(req, int'(m_o), m);
    chk(req, int'(n_o), n);
    chk(req, int'(t_o), t);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;  cyc(3);
    ser_clk  = 1;  cyc(4);
    ser_clk  = 0;  cyc(4);
  endtask

  function automatic logic [13:0] mk(input int t, input logic sp, input int n, input int m);
    return {t[1:0], sp, n[1:0], m[8:0]};
  endfunction

  task automatic send_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_load();
    ser_load = 1; cyc(5);
    ser_load = 0; cyc(5);
  endtask

  task automatic t_reset();
    chk_cfg("R1 reset", 25, 0, 0);
    chk("R1 update", int'(update), 0);
    chk("R10 lock@25", int'(lock_ok), 1);
  endtask

  task automatic t_parallel();
    par_m = 9'd25; par_n = 2'd0; upd_cnt = 0;
    par_load_n = 0; cyc(6);
    chk("R11 same value no pulse", upd_cnt, 0);
    par_m = 9'd30; par_n = 2'd2; cyc(4);
    chk_cfg("R2 transparent", 30, 2, 0);
    chk("R11 one pulse", upd_cnt, 1);
    par_m = 9'd24; cyc(4);
    chk("R2 follow", int'(m_o), 24);
    chk("R10 lock@24", int'(lock_ok), 0);
    par_m = 9'd31; cyc(4);
    chk("R10 lock@31", int'(lock_ok), 1);
    par_m = 9'd32; cyc(4);
    chk("R10 lock@32", int'(lock_ok), 0);
    par_m = 9'd28; par_n = 2'd1; cyc(4);
    par_load_n = 1; cyc(5);
    par_m = 9'd300; par_n = 2'd3; cyc(6);
    chk_cfg("R3 frozen", 28, 1, 0);
  endtask

  task automatic t_serial();
    // spare slot set to 1 must not show anywhere
    upd_cnt = 0;
    send_frame(mk(2, 1'b1, 3, 27));
    chk_cfg("R4 no change while shifting", 28, 1, 0);
    chk("R4 no pulse", upd_cnt, 0);
    pulse_load();
    chk_cfg("R6 transfer", 27, 3, 2);
    chk_cfg("R5 frame order", 27, 3, 2);
    chk("R11 serial pulse", upd_cnt, 1);
    send_bit(1'b1);
    chk_cfg("R6 held after fall", 27, 3, 2);
  endtask

  task automatic t_held();
    logic [13:0] f, f2;
    f  = mk(0, 1'b0, 1, 28);
    f2 = {f[12:0], 1'b1};
    ser_load = 1; cyc(5);
    send_frame(f);
    chk_cfg("R7 held frame", 28, 1, 0);
    send_bit(1'b1);
    chk_cfg("R7 held extra bit", int'(f2[8:0]), int'(f2[10:9]), int'(f2[13:12]));
    ser_load = 0; cyc(5);
    send_bit(1'b0);
    chk_cfg("R4 latched after hold", int'(f2[8:0]), int'(f2[10:9]), int'(f2[13:12]));
  endtask

  task automatic t_mux();
    send_frame(mk(0, 1'b0, 0, 26)); pulse_load();
    fb_div = 1; out_clk = 1; cyc(4);
    chk("R8 sel0 low", int'(test_o), 0);
    send_frame(mk(1, 1'b0, 0, 26)); pulse_load();
    ser_data = 1; cyc(4);
    chk("R8 sel1 data=1", int'(test_o), 1);
    ser_data = 0; cyc(4);
    chk("R8 sel1 data=0", int'(test_o), 0);
    send_frame(mk(2, 1'b0, 0, 26)); pulse_load();
    fb_div = 1; out_clk = 0; cyc(2);
    chk("R8 sel2 fb", int'(test_o), 1);
    fb_div = 0; cyc(2);
    chk("R8 sel2 fb low", int'(test_o), 0);
    send_frame(mk(3, 1'b0, 0, 26)); pulse_load();
    out_clk = 1; cyc(2);
    chk("R8 sel3 out", int'(test_o), 1);
    par_m = 9'd29; par_n = 2'd0; par_load_n = 0; cyc(5);
    chk("R9 parallel forces low", int'(test_o), 0);
    chk("R9 test field kept", int'(t_o), 3);
    par_load_n = 1; cyc(5);
    chk("R8 sel3 after release", int'(test_o), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    cyc(4);
    t_reset();
    rst_n = 1; cyc(3);
    t_reset();
    t_parallel();
    t_serial();
    t_held();
    t_mux();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule